// File: doc/BRIEF.md
# Mixed-Cell Boundary Scan Chain

This block is the serial test register that sits between a device core and its digital pads. Each pad owns one scan cell, and the cell's length depends on what kind of pad it is. An input-only pad uses one bit, a three-state output uses two, and a bidirectional pad uses three. All cells are joined into a single shift path from `tdi` to `tdo`. The pin list is a parameter, so the chain length follows from it.

An external TAP controller supplies the capture, shift and update strobes and two instruction decodes, one for the sample/preload instruction and one for the external-test instruction. When neither decode is active, a one-bit bypass stage forms the serial path instead of the chain. In normal operation the pads follow the core. Under external test they take data and enables from the update latches that were loaded beforehand.

The strobes and decodes are plain level pins sampled on the rising edge of `tck`. They carry no flow control: the TAP controller owns all sequencing, and the chain acts on every rising edge on which a strobe is high.

Top module: `bscan_chain`

## Requirements
- R1: A pad of kind 0 (input-only; the kind is held in `PIN_KINDS[2i+1:2i]`) owns one chain bit, which loads that pad's `pad_in` on capture. The pad is never driven: `pad_oe` is 0.
- R2: A pad of kind 1 (three-state output) owns two chain bits. The lower position, which is shifted in first, is the drive value. The higher position is the enable. Under external test, an enable latch of 1 drives the value latch onto `pad_out` with `pad_oe` = 1, and an enable latch of 0 gives `pad_oe` = 0.
- R3: A pad of kind 2 (bidirectional) owns three chain bits. In shift order they are the captured pad value, the drive value and the enable. On capture, the first bit samples `pad_in`: this is the external level when the pad is not driven, and the pad's own driven value when it is.
- R4: On capture, the drive and enable bits of output and bidirectional cells load that pad's `core_out` and `core_oe`.
- R5: Pad 0 sits at the `tdo` end and the last pad at the `tdi` end. The chain length is the sum of the cell lengths. Each shift strobe moves the chain one position toward `tdo` on the rising edge of `tck`. `tdo` presents the bit nearest the output, and it is refreshed on the falling edge of `tck`.
- R6: The update latches change only on an update strobe while sample/preload or external test is selected. Pad outputs therefore stay steady while the chain shifts or captures.
- R7: While external test is not selected, `pad_out` and `pad_oe` equal `core_out` and `core_oe` for pads of kind 1 or 2, whatever the update latches hold.
- R8: While external test is selected, each output and bidirectional pad takes its drive value and enable from its update latches.
- R9: With neither instruction selected, `tdi` reaches `tdo` through a single bypass bit, which loads 0 on capture. In this state capture, shift and update leave the chain and the latches untouched.
- R10: An active-low reset clears every update latch. With external test selected during or after reset, every `pad_oe` is then 0.
- R11: `core_in` equals `pad_in` for every pad at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling edge of tck |
| capture_dr | input | 1 | Capture strobe from TAP controller |
| shift_dr | input | 1 | Shift strobe from TAP controller |
| update_dr | input | 1 | Update strobe from TAP controller |
| sel_preload | input | 1 | Sample/preload instruction decoded |
| sel_extest | input | 1 | External-test instruction decoded |
| core_out | input | NUM_PINS | Core drive value per pad |
| core_oe | input | NUM_PINS | Core output enable per pad |
| core_in | output | NUM_PINS | Pad value returned to the core |
| pad_in | input | NUM_PINS | Level seen at each pad |
| pad_out | output | NUM_PINS | Value driven to each pad |
| pad_oe | output | NUM_PINS | Driver enable per pad |

## Verification
The bench builds the chain with six pads in the kind order bidirectional, output, input, bidirectional, output, input. This gives a 12-bit chain with a three-bit cell at the `tdo` end, a one-bit cell at the `tdi` end, and every kind at two different offsets. Sixteen rounds sweep arithmetic patterns of core values, enables, external levels and preload vectors. Half of the rounds run under sample/preload and half under external test, so capture is seen both with the core driving the pads and with the latches driving them. A bypass pass and a mid-run reset cover the remaining paths.

// File: rtl/bscan_pkg.sv
`timescale 1ns/1ps
package bscan_pkg;

  localparam logic [1:0] KIND_IN    = 2'd0;
  localparam logic [1:0] KIND_OUT   = 2'd1;
  localparam logic [1:0] KIND_BIDIR = 2'd2;

  // number of chain bits owned by a pad of the given kind
  function automatic int cell_bits(logic [1:0] kind);
    if (kind == KIND_BIDIR) return 3;
    if (kind == KIND_OUT)   return 2;
    return 1;
  endfunction

endpackage

// File: rtl/bscan_bypass.sv
`timescale 1ns/1ps
module bscan_bypass (
  input  logic tck,
  input  logic rst_n,
  input  logic tdi,
  input  logic capture,
  input  logic shift,
  output logic byp
);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)       byp <= 1'b0;
    else if (capture) byp <= 1'b0;
    else if (shift)   byp <= tdi;
  end

  // R9: bypass bit carries tdi across one shift edge
  p_bypass_r9: assert property (@(posedge tck) disable iff (!rst_n)
    (shift && !capture) |=> byp == $past(tdi));

  p_bypass_cap_r9: assert property (@(posedge tck) disable iff (!rst_n)
    capture |=> !byp);

endmodule

// File: rtl/bscan_cell.sv
`timescale 1ns/1ps
module bscan_cell
  import bscan_pkg::*;
#(
  parameter logic [1:0] KIND = KIND_IN
) (
  input  logic tck,
  input  logic rst_n,
  input  logic si,
  output logic so,
  input  logic capture,
  input  logic shift,
  input  logic update,
  input  logic extest,
  input  logic core_out,
  input  logic core_oe,
  input  logic pad_in,
  output logic pad_out,
  output logic pad_oe
);

  localparam int W = cell_bits(KIND);

  generate
    if (KIND == KIND_IN) begin : g_in
      logic sh;
      logic unused_core;

      assign unused_core = core_out ^ core_oe ^ update ^ extest;

      always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)       sh <= 1'b0;
        else if (capture) sh <= pad_in;
        else if (shift)   sh <= si;
      end

      assign so      = sh;
      assign pad_out = 1'b0;
      assign pad_oe  = 1'b0;

      // R1: the single bit samples the pad
      p_cap_in_r1: assert property (@(posedge tck) disable iff (!rst_n)
        capture |=> sh == $past(pad_in));

      // R5: shifting replaces the bit with serial input
      p_shift_in_r5: assert property (@(posedge tck) disable iff (!rst_n)
        (shift && !capture) |=> sh == $past(si));

    end else begin : g_drv
      localparam int DB = W - 2;   // drive bit position
      localparam int EB = W - 1;   // enable bit position

      logic [W-1:0] sh;
      logic [W-1:0] cap_v;
      logic         upd_d;
      logic         upd_e;

      if (W == 3) begin : g_bidir_cap
        assign cap_v = {core_oe, core_out, pad_in};
      end else begin : g_out_cap
        logic unused_pad;
        assign unused_pad = pad_in;
        assign cap_v = {core_oe, core_out};
      end

      always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)       sh <= '0;
        else if (capture) sh <= cap_v;
        else if (shift)   sh <= {si, sh[W-1:1]};
      end

      always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
          upd_d <= 1'b0;
          upd_e <= 1'b0;
        end else if (update) begin
          upd_d <= sh[DB];
          upd_e <= sh[EB];
        end
      end

      assign so      = sh[0];
      assign pad_out = extest ? upd_d : core_out;
      assign pad_oe  = extest ? upd_e : core_oe;

      // R6: latches hold without an update strobe
      p_upd_hold_r6: assert property (@(posedge tck) disable iff (!rst_n)
        !update |=> ($stable(upd_d) && $stable(upd_e)));

      // R5: one position toward tdo per shift edge
      p_shift_r5: assert property (@(posedge tck) disable iff (!rst_n)
        (shift && !capture) |=> sh == {$past(si), $past(sh[W-1:1])});

      // R4: drive and enable bits take the core values
      p_cap_core_r4: assert property (@(posedge tck) disable iff (!rst_n)
        capture |=> (sh[DB] == $past(core_out)) && (sh[EB] == $past(core_oe)));

      if (W == 3) begin : g_bidir_chk
        // R3: the first bit samples the pad level
        p_cap_pad_r3: assert property (@(posedge tck) disable iff (!rst_n)
          capture |=> sh[0] == $past(pad_in));
      end
    end
  endgenerate

endmodule

// File: rtl/bscan_tdo_stage.sv
`timescale 1ns/1ps
module bscan_tdo_stage (
  input  logic tck,
  input  logic rst_n,
  input  logic chain_sel,
  input  logic chain_bit,
  input  logic byp_bit,
  output logic tdo
);

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) tdo <= 1'b0;
    else        tdo <= chain_sel ? chain_bit : byp_bit;
  end

  // R5: tdo presents the chain end, retimed on the falling edge
  p_tdo_chain_r5: assert property (@(negedge tck) disable iff (!rst_n)
    chain_sel |=> tdo == $past(chain_bit));

  // R9: tdo presents the bypass bit when the chain is not selected
  p_tdo_byp_r9: assert property (@(negedge tck) disable iff (!rst_n)
    !chain_sel |=> tdo == $past(byp_bit));

endmodule

// File: rtl/bscan_chain.sv
`timescale 1ns/1ps
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int                      NUM_PINS  = 6,
  parameter logic [2*NUM_PINS-1:0]   PIN_KINDS = 12'h186
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic                tdi,
  output logic                tdo,
  input  logic                capture_dr,
  input  logic                shift_dr,
  input  logic                update_dr,
  input  logic                sel_preload,
  input  logic                sel_extest,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_oe,
  output logic [NUM_PINS-1:0] core_in,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);

  logic              chain_sel;
  logic              c_capture;
  logic              c_shift;
  logic              c_update;
  logic              b_capture;
  logic              b_shift;
  logic              byp;
  logic [NUM_PINS:0] link;

  assign chain_sel = sel_preload | sel_extest;
  assign c_capture = capture_dr & chain_sel;
  assign c_shift   = shift_dr   & chain_sel;
  assign c_update  = update_dr  & chain_sel;
  assign b_capture = capture_dr & ~chain_sel;
  assign b_shift   = shift_dr   & ~chain_sel;

  assign link[NUM_PINS] = tdi;
  assign core_in        = pad_in;

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      bscan_cell #(
        .KIND (PIN_KINDS[2*i +: 2])
      ) u_cell (
        .tck      (tck),
        .rst_n    (trst_n),
        .si       (link[i+1]),
        .so       (link[i]),
        .capture  (c_capture),
        .shift    (c_shift),
        .update   (c_update),
        .extest   (sel_extest),
        .core_out (core_out[i]),
        .core_oe  (core_oe[i]),
        .pad_in   (pad_in[i]),
        .pad_out  (pad_out[i]),
        .pad_oe   (pad_oe[i])
      );
    end
  endgenerate

  bscan_bypass u_bypass (
    .tck     (tck),
    .rst_n   (trst_n),
    .tdi     (tdi),
    .capture (b_capture),
    .shift   (b_shift),
    .byp     (byp)
  );

  bscan_tdo_stage u_tdo (
    .tck       (tck),
    .rst_n     (trst_n),
    .chain_sel (chain_sel),
    .chain_bit (link[0]),
    .byp_bit   (byp),
    .tdo       (tdo)
  );

  // R11: pad level always returned to the core
  p_core_in_r11: assert property (@(posedge tck) disable iff (!trst_n)
    core_in == pad_in);

  // R7: normal mode leaves pads under core control
  p_normal_r7: assert property (@(posedge tck) disable iff (!trst_n)
    !sel_extest |-> ((pad_oe & ~core_oe) == '0));

endmodule

// File: tb/bscan_chain_bench.sv
`timescale 1ns/1ps
module bscan_chain_bench;

  localparam int              NP    = 6;
  localparam logic [2*NP-1:0] KINDS = 12'h186;
  localparam int              LEN   = 12;

  logic          tck = 1'b0;
  logic          trst_n = 1'b0;
  logic          tdi = 1'b0;
  logic          tdo;
  logic          capture_dr = 1'b0;
  logic          shift_dr = 1'b0;
  logic          update_dr = 1'b0;
  logic          sel_preload = 1'b0;
  logic          sel_extest = 1'b0;
  logic [NP-1:0] core_out = '0;
  logic [NP-1:0] core_oe = '0;
  logic [NP-1:0] core_in;
  logic [NP-1:0] pad_in;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;
  logic [NP-1:0] ext = '0;

  logic [NP-1:0] ld = '0;
  logic [NP-1:0] le = '0;
  int            nchk = 0;
  int            nfail = 0;
  bit            done = 1'b0;

  always #2 tck = ~tck;

  for (genvar i = 0; i < NP; i++) begin : g_pad
    assign pad_in[i] = pad_oe[i] ? pad_out[i] : ext[i];
  end

  bscan_chain #(.NUM_PINS(NP), .PIN_KINDS(KINDS)) u_bscan_chain (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .tdo(tdo),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .sel_preload(sel_preload), .sel_extest(sel_extest),
    .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic int kind_of(int i);
    return int'(KINDS[2*i +: 2]);
  endfunction

  function automatic int base_of(int i);
    int b = 0;
    for (int k = 0; k < i; k++) b += kind_of(k) + 1;
    return b;
  endfunction

  function automatic logic exp_oe(int i);
    if (kind_of(i) == 0) return 1'b0;
    return sel_extest ? le[i] : core_oe[i];
  endfunction

  function automatic logic exp_out(int i);
    if (kind_of(i) == 0) return 1'b0;
    return sel_extest ? ld[i] : core_out[i];
  endfunction

  function automatic logic exp_pin(int i);
    return exp_oe(i) ? exp_out(i) : ext[i];
  endfunction

  function automatic logic [LEN-1:0] exp_cap();
    logic [LEN-1:0] e = '0;
    for (int i = 0; i < NP; i++) begin
      int b = base_of(i);
      case (kind_of(i))
        0: e[b] = exp_pin(i);
        1: begin e[b] = core_out[i]; e[b+1] = core_oe[i]; end
        default: begin e[b] = exp_pin(i); e[b+1] = core_out[i]; e[b+2] = core_oe[i]; end
      endcase
    end
    return e;
  endfunction

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_pads(string tag);
    for (int i = 0; i < NP; i++) begin
      string kt = (kind_of(i) == 0) ? "R1" : (kind_of(i) == 1) ? "R2" : "R3";
      check($sformatf("%s %s pad%0d oe", tag, kt, i), int'(pad_oe[i]), int'(exp_oe(i)));
      if (exp_oe(i))
        check($sformatf("%s %s pad%0d out", tag, kt, i), int'(pad_out[i]), int'(exp_out(i)));
      check($sformatf("R11 pad%0d core_in", i), int'(core_in[i]), int'(exp_pin(i)));
    end
  endtask

  task automatic strobe(bit c, bit s, bit u, bit d);
    @(negedge tck); #1;
    capture_dr = c; shift_dr = s; update_dr = u; tdi = d;
  endtask

  task automatic shift_bit(bit d, output bit o);
    @(negedge tck); #1;
    o = tdo;
    capture_dr = 1'b0; shift_dr = 1'b1; update_dr = 1'b0; tdi = d;
  endtask

  task automatic latch_model(logic [LEN-1:0] v);
    for (int i = 0; i < NP; i++) begin
      int b = base_of(i);
      if (kind_of(i) == 1) begin ld[i] = v[b];   le[i] = v[b+1]; end
      if (kind_of(i) == 2) begin ld[i] = v[b+1]; le[i] = v[b+2]; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [LEN-1:0] ecap;
    logic [LEN-1:0] got;
    logic [LEN-1:0] v;
    logic [LEN-1:0] last_v;
    bit             o;

    sel_extest = 1'b1;
    core_oe = '1; core_out = '1; ext = 6'h15;
    repeat (3) @(negedge tck);
    #1;
    check_pads("R10 reset");
    check("R5 reset tdo", int'(tdo), 0);
    sel_extest = 1'b0;
    #1;
    check_pads("R7 reset");
    @(negedge tck); #1 trst_n = 1'b1;

    last_v = '0;
    for (int r = 0; r < 16; r++) begin
      ext      = 6'(r * 11);
      core_out = 6'(r * 7) ^ 6'h2A;
      core_oe  = 6'(r * 13 + 3);
      sel_preload = 1'b1;
      sel_extest  = (r >= 8);
      #1;
      check_pads(sel_extest ? "R8" : "R7");

      strobe(1, 0, 0, 0);
      ecap = exp_cap();
      v = 12'(r * 389) ^ 12'h5A3;
      for (int j = 0; j < LEN; j++) begin
        shift_bit(v[j], o);
        got[j] = o;
        check_pads("R6 shifting");
      end
      strobe(0, 0, 0, 0);
      check_pads("R6 before update");

      for (int i = 0; i < NP; i++) begin
        int b = base_of(i);
        case (kind_of(i))
          0: check($sformatf("R1 capture pad%0d", i), int'(got[b]), int'(ecap[b]));
          1: check($sformatf("R4 capture pad%0d", i), int'(got[b +: 2]), int'(ecap[b +: 2]));
          default: begin
            check($sformatf("R3 capture pad%0d", i), int'(got[b]), int'(ecap[b]));
            check($sformatf("R4 capture pad%0d", i), int'(got[b+1 +: 2]), int'(ecap[b+1 +: 2]));
          end
        endcase
      end
      check("R5 chain vector", int'(got), int'(ecap));

      strobe(0, 0, 1, 0);
      strobe(0, 0, 0, 0);
      latch_model(v);
      last_v = v;
      check_pads(sel_extest ? "R8 after update" : "R7 after update");
      sel_extest = 1'b1;
      #1;
      check_pads("R8 extest");
    end

    // bypass path
    sel_preload = 1'b0;
    sel_extest  = 1'b0;
    strobe(1, 0, 0, 0);
    v = 12'b1101_0010_1101;
    for (int j = 0; j < 10; j++) begin
      shift_bit(v[j], o);
      check($sformatf("R9 bypass bit%0d", j), int'(o), (j == 0) ? 0 : int'(v[j-1]));
    end
    strobe(0, 0, 1, 0);
    strobe(0, 0, 0, 0);
    sel_extest = 1'b1;
    #1;
    check_pads("R9 R6 latches after bypass");
    sel_extest  = 1'b0;
    sel_preload = 1'b1;
    for (int j = 0; j < LEN; j++) begin
      shift_bit(1'b0, o);
      got[j] = o;
    end
    strobe(0, 0, 0, 0);
    check("R9 chain untouched by bypass", int'(got), int'(last_v));

    // reset mid-run
    sel_extest = 1'b1;
    @(negedge tck); #1 trst_n = 1'b0;
    ld = '0; le = '0;
    #1;
    check_pads("R10 mid-run reset");
    @(negedge tck); #1 trst_n = 1'b1;
    strobe(0, 0, 0, 0);
    check_pads("R10 after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule